// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter

This block takes pairs of left and right audio samples from a converter core and sends them one bit at a time on a single serial data line. Each frame has 64 bit slots. Slots 0 to 31 carry the left word and slots 32 to 63 carry the right word. Either side of the link can own the timing. As the timing master, the block divides its sample clock down to a bit clock and a frame sync. As the timing slave, it takes both from outside and resamples them onto its own sample clock before it acts on them.

Samples enter through a valid/ready handshake with a one-entry holding register. The block raises `in_ready` whenever the holding register is empty. Once it accepts a pair, it lowers `in_ready` and keeps it low until the next frame boundary, when the held pair moves to the output stage. A producer that stalls never loses data; it only waits up to one frame. If no pair is waiting when a frame begins, the previous pair is sent again and `underrun` reports this for the whole frame.

Four static mode inputs select master or slave, left or right justification, a level or pulse frame sync, and whether the data line is driven. Together these give sixteen interface modes. A two-bit ratio code sets the sample clock to 128x, 256x or 384x the frame rate. The output-enable signal lets a second transmitter share the data line.

Top module: `pcm_pair_serializer`

## Requirements
- R1: Every frame has 64 bit slots. Slots 0-31 carry the left word and slots 32-63 carry the right word. Each 16-bit word is sent with its most significant bit first.
- R2: With `cfg_rjust`=0, a word fills slot offsets 0-15 of its 32-slot half, and offsets 16-31 send 0.
- R3: With `cfg_rjust`=1, a word fills slot offsets 16-31 of its half, and offsets 0-15 send 0.
- R4: In master mode, `bclk_out` has a period of 2, 4 or 6 sample clocks for `cfg_ratio` codes 0, 1 and 2 (128x, 256x and 384x of a 64-slot frame). Code 3 behaves like code 0.
- R5: In master mode, `sdo` changes only on the sample-clock edge where `bclk_out` rises, and it holds its value for the whole bit period.
- R6: In master mode with `cfg_sync_pulse`=0, `sync_out` is high during slots 0-31 and low during slots 32-63. With `cfg_sync_pulse`=1, it is high during slot 0 only.
- R7: With `cfg_slave`=1, `bclk_out` and `sync_out` stay low. `bclk_in` and `sync_in` pass through a two-stage synchronizer. A frame starts at the first resampled rising edge of `bclk_in` that sees `sync_in` high after it was low at the previous bit edge.
- R8: `in_ready` is high exactly when the one-entry holding register is empty. An accepted pair keeps `in_ready` low until the next frame start, where the pair becomes the output pair.
- R9: At a frame start with no pair held, the previous pair is sent again and `underrun` is 1 for that frame. Otherwise `underrun` is 0.
- R10: `sdo_oe` equals `cfg_out_en`, so the line can be released to another driver.
- R11: While `rst_n` is low, `sdo`, `bclk_out`, `sync_out` and `underrun` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1: take bit clock and sync from outside |
| cfg_rjust | input | 1 | 1: word in the last 16 slots of each half |
| cfg_sync_pulse | input | 1 | 1: one-slot sync pulse, 0: half-frame sync level |
| cfg_out_en | input | 1 | Drive the data line |
| cfg_ratio | input | 2 | Sample clock to frame rate ratio code |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | WORD_W | Left sample |
| in_right | input | WORD_W | Right sample |
| bclk_in | input | 1 | External bit clock (slave mode) |
| sync_in | input | 1 | External frame sync (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| sync_out | output | 1 | Generated frame sync (master mode) |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Enable for the serial data driver |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
In master mode, `sdo`, `sync_out`, `underrun` and a rising `in_ready` all change on the same clock edge that raises `bclk_out`. In slave mode, they change on the third clock edge after a `bclk_in` change, two edges for the synchronizer and one for the state. The bench therefore reads each bit at the falling edge of the relevant bit clock, mid-bit and well clear of either update. In master mode, it also reads `sdo` at each rising edge to confirm that the value was already final there. Frame alignment comes from the cycle in which `in_ready` returns high, which is the frame start that loaded the pushed pair.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  typedef enum logic [1:0] {
    RATIO_X128 = 2'd0,
    RATIO_X256 = 2'd1,
    RATIO_X384 = 2'd2,
    RATIO_ALT  = 2'd3
  } ratio_e;

  // sample clocks per half bit period for a 64-slot frame
  function automatic logic [1:0] half_len(input logic [1:0] code);
    case (ratio_e'(code))
      RATIO_X256: half_len = 2'd2;
      RATIO_X384: half_len = 2'd3;
      default:    half_len = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/ssr_bitclk_gen.sv
`timescale 1ns/1ps
module ssr_bitclk_gen
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] ratio,
  output logic       bclk,
  output logic       tick
);
  logic [1:0] cnt;
  logic [1:0] last;

  assign last = half_len(ratio) - 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 2'd1;
    end
  end

  // the state advances on the edge that raises bclk
  assign tick = en && (cnt == last) && !bclk;
endmodule

// File: rtl/ssr_slave_front.sv
`timescale 1ns/1ps
module ssr_slave_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic sync_in,
  output logic tick,
  output logic frame_go
);
  logic [STAGES-1:0] bsh;
  logic [STAGES-1:0] ssh;
  logic              b_last;
  logic              s_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsh    <= '0;
      ssh    <= '0;
      b_last <= 1'b0;
      s_last <= 1'b0;
    end else begin
      bsh    <= {bsh[STAGES-2:0], bclk_in};
      ssh    <= {ssh[STAGES-2:0], sync_in};
      b_last <= bsh[STAGES-1];
      if (tick) s_last <= ssh[STAGES-1];
    end
  end

  assign tick     = bsh[STAGES-1] & ~b_last;
  assign frame_go = tick & ssh[STAGES-1] & ~s_last;
endmodule

// File: rtl/ssr_framer.sv
`timescale 1ns/1ps
module ssr_framer #(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frame_go,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic [SLOT_W-1:0] slot,
  output logic [WORD_W-1:0] cur_l,
  output logic [WORD_W-1:0] cur_r,
  output logic              underrun
);
  logic              pend_v;
  logic [WORD_W-1:0] pend_l;
  logic [WORD_W-1:0] pend_r;
  logic              accept;
  logic              load;

  assign in_ready = !pend_v;
  assign accept   = in_valid && in_ready;
  assign load     = tick && frame_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= '1;
      pend_v   <= 1'b0;
      pend_l   <= '0;
      pend_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      underrun <= 1'b0;
    end else begin
      if (tick) slot <= frame_go ? '0 : slot + SLOT_W'(1);
      if (load) begin
        underrun <= !pend_v;
        if (pend_v) begin
          cur_l <= pend_l;
          cur_r <= pend_r;
        end
      end
      if (load && pend_v) begin
        pend_v <= 1'b0;
      end else if (accept) begin
        pend_v <= 1'b1;
        pend_l <= in_left;
        pend_r <= in_right;
      end
    end
  end
endmodule

// File: rtl/ssr_bit_pick.sv
`timescale 1ns/1ps
module ssr_bit_pick #(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              rjust,
  input  logic [WORD_W-1:0] cur_l,
  input  logic [WORD_W-1:0] cur_r,
  output logic              bit_o
);
  localparam int POS_W = SLOT_W - 1;
  localparam int HALF  = 1 << POS_W;
  localparam int IDX_W = $clog2(WORD_W);

  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] word;
  int                off;

  always_comb begin
    pos  = slot[POS_W-1:0];
    word = slot[SLOT_W-1] ? cur_r : cur_l;
    off  = rjust ? int'(pos) - (HALF - WORD_W) : int'(pos);
    if (off >= 0 && off < WORD_W) bit_o = word[IDX_W'(WORD_W - 1 - off)];
    else                          bit_o = 1'b0;
  end
endmodule

// File: rtl/pcm_pair_serializer.sv
`timescale 1ns/1ps
module pcm_pair_serializer
  import ssr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int HALF_SLOTS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave,
  input  logic              cfg_rjust,
  input  logic              cfg_sync_pulse,
  input  logic              cfg_out_en,
  input  logic [1:0]        cfg_ratio,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              bclk_in,
  input  logic              sync_in,
  output logic              bclk_out,
  output logic              sync_out,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              underrun
);
  localparam int SLOT_W = $clog2(2 * HALF_SLOTS);

  logic              m_tick, m_bclk;
  logic              s_tick, s_frame;
  logic              tick, frame_go;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] cur_l, cur_r;

  ssr_bitclk_gen u_gen (
    .clk(clk), .rst_n(rst_n), .en(!cfg_slave), .ratio(cfg_ratio),
    .bclk(m_bclk), .tick(m_tick)
  );

  ssr_slave_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .sync_in(sync_in),
    .tick(s_tick), .frame_go(s_frame)
  );

  assign tick     = cfg_slave ? s_tick : m_tick;
  assign frame_go = cfg_slave ? s_frame : (&slot);

  ssr_framer #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_go(frame_go),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .slot(slot), .cur_l(cur_l), .cur_r(cur_r), .underrun(underrun)
  );

  ssr_bit_pick #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_pick (
    .slot(slot), .rjust(cfg_rjust), .cur_l(cur_l), .cur_r(cur_r), .bit_o(sdo)
  );

  assign bclk_out = m_bclk;
  assign sync_out = !cfg_slave &&
                    (cfg_sync_pulse ? (slot == '0) : !slot[SLOT_W-1]);
  assign sdo_oe   = cfg_out_en;
endmodule

// File: rtl/ssr_checker.sv
`timescale 1ns/1ps
module ssr_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_slave,
  input logic bclk_out,
  input logic sync_out,
  input logic sdo,
  input logic underrun,
  input logic in_valid,
  input logic in_ready
);
  // R5: master data moves only with a rising bit clock
  a_r5_sdo_on_bclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && !$rose(bclk_out)) |-> $stable(sdo));

  // R7: generated timing stays quiet in slave mode
  a_r7_slave_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_slave |-> (!bclk_out && !sync_out));

  // R8: an accepted pair fills the holding register
  a_r8_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8: in master mode ready returns only at a bit clock rise
  a_r8_ready_rises_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && !in_ready) |=> (!in_ready || $rose(bclk_out)));

  // R9: the underrun flag changes only at bit boundaries
  a_r9_underrun_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && !$rose(bclk_out)) |-> $stable(underrun));
endmodule

bind pcm_pair_serializer ssr_checker u_chk (.*);

// File: tb/sim_pcm_pair_serializer.sv
`timescale 1ns/1ps
module sim_pcm_pair_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_slave = 1'b0, cfg_rjust = 1'b0, cfg_sync_pulse = 1'b0, cfg_out_en = 1'b1;
  logic [1:0]  cfg_ratio = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic        bclk_in, sync_in;
  logic        bclk_out, sync_out, sdo, sdo_oe, underrun;
  logic        slave_run = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  pcm_pair_serializer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_rjust(cfg_rjust),
    .cfg_sync_pulse(cfg_sync_pulse), .cfg_out_en(cfg_out_en), .cfg_ratio(cfg_ratio),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .bclk_in(bclk_in), .sync_in(sync_in), .bclk_out(bclk_out), .sync_out(sync_out),
    .sdo(sdo), .sdo_oe(sdo_oe), .underrun(underrun)
  );

  // external timing source for slave mode: 16 sample clocks per bit
  initial begin
    int ph;
    int es;
    bclk_in = 1'b0;
    sync_in = 1'b1;
    ph = 0;
    es = 63;
    forever begin
      @(negedge clk);
      if (!slave_run) begin
        bclk_in = 1'b0; sync_in = 1'b1; ph = 0; es = 63;
      end else begin
        if (ph == 0) begin bclk_in = 1'b1; es = (es + 1) % 64; end
        if (ph == 8) begin bclk_in = 1'b0; sync_in = (((es + 1) % 64) < 32); end
        ph = (ph + 1) % 16;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [15:0] l, input logic [15:0] r, input bit rj);
    logic [63:0] v;
    v = '0;
    for (int s = 0; s < 64; s++) begin
      int p;
      int o;
      logic [15:0] w;
      p = s % 32;
      w = (s < 32) ? l : r;
      o = rj ? p - 16 : p;
      if (o >= 0 && o < 16) v[63-s] = w[15-o];
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_sync(input bit pulse);
    logic [63:0] v;
    for (int s = 0; s < 64; s++) v[63-s] = pulse ? (s == 0) : (s < 32);
    return v;
  endfunction

  task automatic do_reset(input bit slv, input bit rj, input bit pl, input logic [1:0] ra);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_slave = slv; cfg_rjust = rj; cfg_sync_pulse = pl; cfg_ratio = ra;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    while (1) begin
      @(negedge clk);
      if (in_ready) begin
        in_left = l; in_right = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wait_ready();
    while (!in_ready) begin @(posedge clk); #1; end
  endtask

  task automatic wait_rise(output int n);
    logic p;
    n = 0;
    p = bclk_out;
    while (1) begin
      @(posedge clk); #1;
      n++;
      if (!p && bclk_out) break;
      p = bclk_out;
    end
  endtask

  task automatic capture(input bit slv, output logic [63:0] df, output logic [63:0] dr,
                         output logic [63:0] sy, output logic uf, output logic qb);
    qb = 1'b0;
    uf = 1'b0;
    for (int i = 0; i < 64; i++) begin
      logic p;
      logic rs;
      p  = slv ? bclk_in : bclk_out;
      rs = sdo;
      while (1) begin
        @(posedge clk); #1;
        if (slv && (bclk_out || sync_out)) qb = 1'b1;
        if (!p && (slv ? bclk_in : bclk_out)) rs = sdo;
        if (p && !(slv ? bclk_in : bclk_out)) break;
        p = slv ? bclk_in : bclk_out;
      end
      df[63-i] = sdo;
      dr[63-i] = rs;
      sy[63-i] = sync_out;
      if (i == 0) uf = underrun;
    end
  endtask

  task automatic run_master(input int ra, input bit rj, input bit pl, input int k);
    logic [15:0] l, r;
    logic [63:0] df, dr, sy, ef;
    logic uf, qb;
    int n, h;
    do_reset(1'b0, rj, pl, 2'(ra));
    h = (ra == 1) ? 2 : (ra == 2) ? 3 : 1;
    wait_rise(n);
    wait_rise(n);
    chk(n == 2 * h, "R4 bit clock period", 64'(n), 64'(2 * h));
    l = 16'hC35A ^ 16'(k * 16'h1111);
    r = 16'h81E7 ^ 16'(k * 16'h0D2B);
    ef = exp_frame(l, r, rj);
    push(l, r);
    chk(in_ready == 1'b0, "R8 ready low while holding", 64'(in_ready), 64'd0);
    wait_ready();
    capture(1'b0, df, dr, sy, uf, qb);
    chk(df == ef, rj ? "R1 R3 right-justified frame" : "R1 R2 left-justified frame", df, ef);
    chk(dr == df, "R5 sdo final at bclk rise", dr, df);
    chk(sy == exp_sync(pl), pl ? "R6 pulse sync" : "R6 level sync", sy, exp_sync(pl));
    chk(uf == 1'b0, "R9 no underrun with fresh pair", 64'(uf), 64'd0);
    capture(1'b0, df, dr, sy, uf, qb);
    chk(df == ef, "R9 previous pair repeated", df, ef);
    chk(uf == 1'b1, "R9 underrun flagged", 64'(uf), 64'd1);
    if (k == 0) begin
      @(negedge clk); cfg_out_en = 1'b0; #1;
      chk(sdo_oe == 1'b0, "R10 output released", 64'(sdo_oe), 64'd0);
      @(negedge clk); cfg_out_en = 1'b1; #1;
      chk(sdo_oe == 1'b1, "R10 output driven", 64'(sdo_oe), 64'd1);
    end
  endtask

  task automatic run_slave(input bit rj);
    logic [15:0] l, r;
    logic [63:0] df, dr, sy, ef;
    logic uf, qb;
    do_reset(1'b1, rj, 1'b0, 2'd0);
    #1;
    chk(!bclk_out && !sync_out, "R7 slave outputs low", {62'd0, bclk_out, sync_out}, 64'd0);
    slave_run = 1'b1;
    l = rj ? 16'h1F2E : 16'hB00C;
    r = rj ? 16'hE4D1 : 16'h7A35;
    ef = exp_frame(l, r, rj);
    push(l, r);
    wait_ready();
    capture(1'b1, df, dr, sy, uf, qb);
    chk(df == ef, "R7 slave frame data", df, ef);
    chk(qb == 1'b0, "R7 slave timing outputs quiet", 64'(qb), 64'd0);
    chk(uf == 1'b0, "R9 slave fresh pair", 64'(uf), 64'd0);
    capture(1'b1, df, dr, sy, uf, qb);
    chk(df == ef, "R9 slave repeat", df, ef);
    chk(uf == 1'b1, "R9 slave underrun", 64'(uf), 64'd1);
    @(negedge clk);
    slave_run = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk(sdo == 1'b0 && bclk_out == 1'b0 && sync_out == 1'b0 && underrun == 1'b0,
        "R11 outputs low in reset", {60'd0, sdo, bclk_out, sync_out, underrun}, 64'd0);
    chk(in_ready == 1'b1, "R11 ready high in reset", 64'(in_ready), 64'd1);
    for (int ra = 0; ra < 4; ra++)
      for (int rj = 0; rj < 2; rj++)
        for (int pl = 0; pl < 2; pl++)
          run_master(ra, rj[0], pl[0], ra * 4 + rj * 2 + pl);
    run_slave(1'b0);
    run_slave(1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule